// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block is an up/down counter whose clock, start, stop and reinitialisation come from a 4-bit slave-mode code and one selected trigger. It drives a counter value, a direction flag, a one-cycle update pulse and a one-cycle trigger pulse. It is meant to sit inside a larger timer. The configuration inputs (`slv_mode`, `trig_sel`, `pol_inv`, `arr_val`) are treated as static while the counter runs.

Three encoder variants follow two quadrature inputs. The other modes use the trigger in different ways:

- **Reset mode** clears the counter on an active trigger edge.
- **Gated mode** counts only while the trigger level is high.
- **Trigger mode** starts the counter on an active edge.
- **External-clock mode** steps the counter on each active edge.
- **Combined mode** clears and starts the counter on the same edge.

Every asynchronous input goes through a two-flop synchroniser and then an edge detector. This gives a fixed latency of three clock edges from an input change to the counter reacting, in every mode.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While and after reset, `cnt_val` is 0, `cnt_down` is 0, `upd_evt` is 0 and `trg_evt` is 0.
- R2: With `slv_mode` 0000, or any code from 1001 to 1111, the counter adds one on each clock while `cnt_en` is 1. It holds its value while `cnt_en` is 0.
- R3: When counting up at `arr_val`, the next step goes to 0 and raises `upd_evt` for exactly one cycle. When counting down at 0, the next step goes to `arr_val` and also raises `upd_evt`.
- R4: Mode 0001 steps only on TI1 transitions while `cnt_en` is 1. The step is up when the new TI1 level differs from TI2, and down otherwise. `cnt_down` shows the direction of the last step.
- R5: Mode 0010 steps only on TI2 transitions. The step is up when the new TI2 level equals TI1, and down otherwise.
- R6: Mode 0011 steps on transitions of either input, so one full quadrature cycle moves the counter by four. Stepping back below 0 wraps to `arr_val`.
- R7: In mode 0100 the counter counts as in R2. An active trigger edge sets it to 0 and raises `upd_evt`, even when `cnt_en` is 0.
- R8: In mode 0101 the counter steps on each clock only while `cnt_en` is 1 and the trigger level is high. When the trigger goes low, the counter keeps its value.
- R9: In mode 0110 an active trigger edge starts counting even if `cnt_en` is 0, without clearing the counter. Counting then continues after the trigger falls.
- R10: In mode 0111 the counter adds one per active trigger edge, and only while `cnt_en` is 1.
- R11: In mode 1000 an active trigger edge sets the counter to 0, raises `upd_evt` and starts counting as in R9.
- R12: `trig_sel` picks the trigger as follows:
  - 000 to 011: `itr_in[0]` to `itr_in[3]`.
  - 100: a one-cycle pulse on every TI1 transition.
  - 101: TI1.
  - 110: TI2.
  - 111: `etr_in`.

  `pol_inv[0]`, `pol_inv[1]` and `pol_inv[2]` invert TI1, TI2 and `etr_in`, so a falling pin edge becomes the active edge. `trg_evt` pulses for one cycle on each active trigger edge.
- R13: Mode 0101 together with `trig_sel` 100 sets `cfg_err` to 1, and the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| slv_mode | input | 4 | Slave-mode code |
| trig_sel | input | 3 | Trigger source select |
| pol_inv | input | 3 | Input inversion: bit 0 TI1, bit 1 TI2, bit 2 external trigger |
| itr_in | input | N_ITR (4) | Internal trigger lines |
| ti1_in | input | 1 | Filtered timer input 1 |
| ti2_in | input | 1 | Filtered timer input 2 |
| etr_in | input | 1 | External trigger input |
| arr_val | input | CNT_W (16) | Auto-reload limit |
| cnt_val | output | CNT_W (16) | Counter value |
| cnt_down | output | 1 | 1 when the last encoder step was downward |
| upd_evt | output | 1 | One-cycle update event |
| trg_evt | output | 1 | One-cycle trigger event |
| cfg_err | output | 1 | Illegal gated configuration |

## Verification
The bench builds the block with `CNT_W` = 8 and `N_ITR` = 4. With the narrower counter, a full-range limit of 255 could be wrapped in a few hundred cycles, while small `arr_val` settings make both the upward and the downward wrap appear within a handful of steps. Four internal trigger lines let the trigger and combined tests drive the lowest and the highest select code.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int MODE_W = 4;
  localparam int TSEL_W = 3;

  localparam logic [MODE_W-1:0] SM_OFF    = 4'd0;
  localparam logic [MODE_W-1:0] SM_ENC1   = 4'd1;
  localparam logic [MODE_W-1:0] SM_ENC2   = 4'd2;
  localparam logic [MODE_W-1:0] SM_ENC3   = 4'd3;
  localparam logic [MODE_W-1:0] SM_RESET  = 4'd4;
  localparam logic [MODE_W-1:0] SM_GATED  = 4'd5;
  localparam logic [MODE_W-1:0] SM_TRIG   = 4'd6;
  localparam logic [MODE_W-1:0] SM_EXTCLK = 4'd7;
  localparam logic [MODE_W-1:0] SM_COMBO  = 4'd8;

  localparam logic [TSEL_W-1:0] TS_EDGE = 3'b100;
  localparam logic [TSEL_W-1:0] TS_TI1  = 3'b101;
  localparam logic [TSEL_W-1:0] TS_TI2  = 3'b110;
  localparam logic [TSEL_W-1:0] TS_ETR  = 3'b111;

  // one-hot decode of the slave-mode code; reserved codes fall to off
  typedef struct packed {
    logic off;
    logic enc1;
    logic enc2;
    logic enc3;
    logic rst;
    logic gate;
    logic trig;
    logic ext;
    logic combo;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(logic [MODE_W-1:0] m);
    mode_dec_t d;
    d = '0;
    case (m)
      SM_ENC1:   d.enc1  = 1'b1;
      SM_ENC2:   d.enc2  = 1'b1;
      SM_ENC3:   d.enc3  = 1'b1;
      SM_RESET:  d.rst   = 1'b1;
      SM_GATED:  d.gate  = 1'b1;
      SM_TRIG:   d.trig  = 1'b1;
      SM_EXTCLK: d.ext   = 1'b1;
      SM_COMBO:  d.combo = 1'b1;
      default:   d.off   = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, p_q;
    logic s1_d, s2_d, p_d;

    always_comb begin
      s1_d = din[i];
      s2_d = s1_q;
      p_d  = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        p_q  <= 1'b0;
      end else begin
        s1_q <= s1_d;
        s2_q <= s2_d;
        p_q  <= p_d;
      end
    end

    assign lvl[i] = s2_q;
    assign prv[i] = p_q;
  end

endmodule

// File: rtl/tsc_trig.sv
module tsc_trig
  import tsc_pkg::*;
#(
  parameter int N_ITR = 4,
  localparam int SYNC_W = N_ITR + 3,
  localparam int I_TI1  = N_ITR,
  localparam int I_TI2  = N_ITR + 1,
  localparam int I_ETR  = N_ITR + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SYNC_W-1:0] lvl,
  input  logic [SYNC_W-1:0] prv,
  input  logic [2:0]        pol_inv,
  input  logic [TSEL_W-1:0] trig_sel,
  output logic              ti1_lvl,
  output logic              ti2_lvl,
  output logic              ti1_tog,
  output logic              ti2_tog,
  output logic              trgi_lvl,
  output logic              trgi_rise,
  output logic              sel_edge
);

  logic ti1_prv, ti2_prv, etr_lvl, etr_prv;
  logic src_lvl, src_prv;
  int   itr_idx;

  always_comb begin
    ti1_lvl = lvl[I_TI1] ^ pol_inv[0];
    ti1_prv = prv[I_TI1] ^ pol_inv[0];
    ti2_lvl = lvl[I_TI2] ^ pol_inv[1];
    ti2_prv = prv[I_TI2] ^ pol_inv[1];
    etr_lvl = lvl[I_ETR] ^ pol_inv[2];
    etr_prv = prv[I_ETR] ^ pol_inv[2];
    ti1_tog = ti1_lvl ^ ti1_prv;
    ti2_tog = ti2_lvl ^ ti2_prv;
  end

  always_comb begin
    itr_idx  = int'(trig_sel[1:0]);
    src_lvl  = 1'b0;
    src_prv  = 1'b0;
    sel_edge = 1'b0;
    case (trig_sel)
      TS_EDGE: sel_edge = 1'b1;
      TS_TI1:  begin src_lvl = ti1_lvl; src_prv = ti1_prv; end
      TS_TI2:  begin src_lvl = ti2_lvl; src_prv = ti2_prv; end
      TS_ETR:  begin src_lvl = etr_lvl; src_prv = etr_prv; end
      default: begin
        if (itr_idx < N_ITR) begin
          src_lvl = lvl[itr_idx];
          src_prv = prv[itr_idx];
        end
      end
    endcase
  end

  // the TI1 toggle pulse is already one cycle wide, so it is its own edge
  always_comb begin
    if (sel_edge) begin
      trgi_lvl  = ti1_tog;
      trgi_rise = ti1_tog;
    end else begin
      trgi_lvl  = src_lvl;
      trgi_rise = src_lvl & ~src_prv;
    end
  end

  p_rise_has_lvl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    trgi_rise |-> trgi_lvl);

endmodule

// File: rtl/tsc_core.sv
module tsc_core
  import tsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [MODE_W-1:0] slv_mode,
  input  logic              sel_edge,
  input  logic              ti1_lvl,
  input  logic              ti2_lvl,
  input  logic              ti1_tog,
  input  logic              ti2_tog,
  input  logic              trgi_lvl,
  input  logic              trgi_rise,
  input  logic [CNT_W-1:0]  arr_val,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              cnt_down,
  output logic              upd_evt,
  output logic              trg_evt,
  output logic              cfg_err
);

  mode_dec_t md;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic dir_q, dir_d, upd_q, upd_d, trg_q, trg_d, run_q, run_d;
  logic err, reinit, running, fwd_stp, enc_stp, enc_up, is_enc;
  logic is_off, is_gate, is_ext;

  always_comb begin
    md      = decode_mode(slv_mode);
    is_off  = md.off;
    is_gate = md.gate;
    is_ext  = md.ext;
    is_enc  = md.enc1 | md.enc2 | md.enc3;
    err     = md.gate & sel_edge;
    reinit  = (md.rst | md.combo) & trgi_rise;
    running = cnt_en | run_q;
  end

  // start latch for trigger and combined modes
  always_comb begin
    run_d = run_q;
    if (md.trig | md.combo) begin
      if (trgi_rise) run_d = 1'b1;
    end else begin
      run_d = 1'b0;
    end
  end

  // encoder step decision
  always_comb begin
    enc_stp = 1'b0;
    enc_up  = 1'b0;
    if (cnt_en) begin
      if (md.enc1 && ti1_tog) begin
        enc_stp = 1'b1;
        enc_up  = ti1_lvl ^ ti2_lvl;
      end else if (md.enc2 && ti2_tog) begin
        enc_stp = 1'b1;
        enc_up  = ~(ti1_lvl ^ ti2_lvl);
      end else if (md.enc3 && (ti1_tog ^ ti2_tog)) begin
        enc_stp = 1'b1;
        enc_up  = ti1_tog ? (ti1_lvl ^ ti2_lvl) : ~(ti1_lvl ^ ti2_lvl);
      end
    end
  end

  // forward step for the non-encoder modes
  always_comb begin
    fwd_stp = 1'b0;
    if (md.off | md.rst) fwd_stp = cnt_en;
    else if (md.gate)    fwd_stp = cnt_en & trgi_lvl & ~err;
    else if (md.trig | md.combo) fwd_stp = running;
    else if (md.ext)     fwd_stp = cnt_en & trgi_rise;
  end

  always_comb begin
    cnt_d = cnt_q;
    upd_d = 1'b0;
    dir_d = is_enc ? dir_q : 1'b0;
    trg_d = trgi_rise;
    if (reinit) begin
      cnt_d = '0;
      upd_d = 1'b1;
    end else if (fwd_stp || (enc_stp && enc_up)) begin
      if (enc_stp) dir_d = 1'b0;
      if (cnt_q >= arr_val) begin
        cnt_d = '0;
        upd_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (enc_stp) begin
      dir_d = 1'b1;
      if (cnt_q == '0) begin
        cnt_d = arr_val;
        upd_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      upd_q <= 1'b0;
      trg_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      upd_q <= upd_d;
      trg_q <= trg_d;
      run_q <= run_d;
    end
  end

  assign cnt_val  = cnt_q;
  assign cnt_down = dir_q;
  assign upd_evt  = upd_q;
  assign trg_evt  = trg_q;
  assign cfg_err  = err;

  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_off && !cnt_en) |=> $stable(cnt_q));

  p_upd_up_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !dir_q) |-> (cnt_q == '0));

  p_reinit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (cnt_q == '0) && upd_q);

  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_gate && !trgi_lvl) |=> $stable(cnt_q));

  p_ext_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ext && !trgi_rise) |=> $stable(cnt_q));

  p_err_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tsc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_ITR = 4,
  localparam int SYNC_W = N_ITR + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [3:0]        slv_mode,
  input  logic [2:0]        trig_sel,
  input  logic [2:0]        pol_inv,
  input  logic [N_ITR-1:0]  itr_in,
  input  logic              ti1_in,
  input  logic              ti2_in,
  input  logic              etr_in,
  input  logic [CNT_W-1:0]  arr_val,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              cnt_down,
  output logic              upd_evt,
  output logic              trg_evt,
  output logic              cfg_err
);

  logic [SYNC_W-1:0] raw, lvl, prv;
  logic ti1_lvl, ti2_lvl, ti1_tog, ti2_tog, trgi_lvl, trgi_rise, sel_edge;

  assign raw = {etr_in, ti2_in, ti1_in, itr_in};

  tsc_sync #(.W(SYNC_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw),
    .lvl  (lvl),
    .prv  (prv)
  );

  tsc_trig #(.N_ITR(N_ITR)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .prv      (prv),
    .pol_inv  (pol_inv),
    .trig_sel (trig_sel),
    .ti1_lvl  (ti1_lvl),
    .ti2_lvl  (ti2_lvl),
    .ti1_tog  (ti1_tog),
    .ti2_tog  (ti2_tog),
    .trgi_lvl (trgi_lvl),
    .trgi_rise(trgi_rise),
    .sel_edge (sel_edge)
  );

  tsc_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .slv_mode (slv_mode),
    .sel_edge (sel_edge),
    .ti1_lvl  (ti1_lvl),
    .ti2_lvl  (ti2_lvl),
    .ti1_tog  (ti1_tog),
    .ti2_tog  (ti2_tog),
    .trgi_lvl (trgi_lvl),
    .trgi_rise(trgi_rise),
    .arr_val  (arr_val),
    .cnt_val  (cnt_val),
    .cnt_down (cnt_down),
    .upd_evt  (upd_evt),
    .trg_evt  (trg_evt),
    .cfg_err  (cfg_err)
  );

endmodule

// File: tb/sim_tmr_slave_ctrl.sv
module sim_tmr_slave_ctrl;

  localparam int CW = 8;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cnt_en;
  logic [3:0] slv_mode;
  logic [2:0] trig_sel, pol_inv;
  logic [NI-1:0] itr_in;
  logic ti1_in, ti2_in, etr_in;
  logic [CW-1:0] arr_val, cnt_val;
  logic cnt_down, upd_evt, trg_evt, cfg_err;

  int checks = 0;
  int errors = 0;
  int n_upd = 0;
  int n_trg = 0;

  always #4 clk = ~clk;

  tmr_slave_ctrl #(.CNT_W(CW), .N_ITR(NI)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .slv_mode(slv_mode),
    .trig_sel(trig_sel), .pol_inv(pol_inv), .itr_in(itr_in),
    .ti1_in(ti1_in), .ti2_in(ti2_in), .etr_in(etr_in), .arr_val(arr_val),
    .cnt_val(cnt_val), .cnt_down(cnt_down), .upd_evt(upd_evt),
    .trg_evt(trg_evt), .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    if (rst_n && upd_evt) n_upd++;
    if (rst_n && trg_evt) n_trg++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0; slv_mode = 4'd0; trig_sel = 3'd0;
    pol_inv = 3'd0; itr_in = '0; ti1_in = 1'b0; ti2_in = 1'b0;
    etr_in = 1'b0; arr_val = 8'd200;
    wt(2);
    rst_n = 1'b1;
    wt(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cnt", cnt_val, 0);
    chk("R1 dir", cnt_down, 0);
    chk("R1 upd", upd_evt, 0);
    chk("R1 trg", trg_evt, 0);
  endtask

  task automatic t_free();
    do_reset();
    cnt_en = 1'b1; wt(10);
    chk("R2 count", cnt_val, 10);
    cnt_en = 1'b0; wt(4);
    chk("R2 hold", cnt_val, 10);
    slv_mode = 4'b1101; cnt_en = 1'b1; wt(5);
    chk("R2 reserved", cnt_val, 15);
  endtask

  task automatic t_wrap();
    do_reset();
    arr_val = 8'd5; cnt_en = 1'b1;
    for (int n = 1; n <= 13; n++) begin
      wt(1);
      chk("R3 wrap cnt", cnt_val, n % 6);
      chk("R3 wrap upd", upd_evt, (n % 6 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_enc1();
    do_reset();
    slv_mode = 4'd1; cnt_en = 1'b1;
    ti1_in = 1'b1; wt(5);
    chk("R4 ti1 rise", cnt_val, 1);
    ti2_in = 1'b1; wt(5);
    chk("R4 ti2 ignored", cnt_val, 1);
    ti1_in = 1'b0; wt(5);
    chk("R4 ti1 fall", cnt_val, 2);
    chk("R4 dir up", cnt_down, 0);
    ti1_in = 1'b1; wt(5);
    chk("R4 reverse", cnt_val, 1);
    chk("R4 dir down", cnt_down, 1);
  endtask

  task automatic t_enc2();
    do_reset();
    slv_mode = 4'd2; cnt_en = 1'b1;
    ti1_in = 1'b1; wt(5);
    chk("R5 ti1 ignored", cnt_val, 0);
    ti2_in = 1'b1; wt(5);
    ti1_in = 1'b0; wt(5);
    ti2_in = 1'b0; wt(5);
    chk("R5 forward", cnt_val, 2);
    ti2_in = 1'b1; wt(5);
    chk("R5 reverse", cnt_val, 1);
    chk("R5 dir", cnt_down, 1);
  endtask

  task automatic t_enc3();
    int u0c;
    do_reset();
    slv_mode = 4'd3; cnt_en = 1'b1; arr_val = 8'd10;
    ti1_in = 1'b1; wt(5); ti2_in = 1'b1; wt(5);
    ti1_in = 1'b0; wt(5); ti2_in = 1'b0; wt(5);
    chk("R6 full cycle", cnt_val, 4);
    u0c = n_upd;
    ti2_in = 1'b1; wt(5); ti1_in = 1'b1; wt(5);
    ti2_in = 1'b0; wt(5); ti1_in = 1'b0; wt(5);
    chk("R6 back to zero", cnt_val, 0);
    ti2_in = 1'b1; wt(5);
    chk("R6 down wrap", cnt_val, 10);
    chk("R6 dir", cnt_down, 1);
    chk("R3 down wrap upd", n_upd - u0c, 1);
  endtask

  task automatic t_rstmode();
    int u0c, t0c;
    do_reset();
    slv_mode = 4'd4; trig_sel = 3'b101; cnt_en = 1'b1;
    wt(20);
    chk("R7 counting", cnt_val, 20);
    u0c = n_upd; t0c = n_trg;
    ti1_in = 1'b1; wt(5);
    chk("R7 cleared", cnt_val, 2);
    chk("R7 upd", n_upd - u0c, 1);
    chk("R12 trg pulse", n_trg - t0c, 1);
  endtask

  task automatic t_gated();
    do_reset();
    slv_mode = 4'd5; trig_sel = 3'b111; cnt_en = 1'b1;
    wt(10);
    chk("R8 gate low", cnt_val, 0);
    etr_in = 1'b1; wt(10);
    chk("R8 gate high", cnt_val, 8);
    etr_in = 1'b0; wt(10);
    chk("R8 stop", cnt_val, 10);
    wt(5);
    chk("R8 hold", cnt_val, 10);
  endtask

  task automatic t_trig();
    int t0c;
    do_reset();
    slv_mode = 4'd6; trig_sel = 3'b000;
    wt(5);
    chk("R9 idle", cnt_val, 0);
    t0c = n_trg;
    itr_in[0] = 1'b1; wt(10);
    chk("R9 started", cnt_val, 7);
    itr_in[0] = 1'b0; wt(10);
    chk("R9 keeps running", cnt_val, 17);
    chk("R12 rising only", n_trg - t0c, 1);
  endtask

  task automatic t_combo();
    int u0c;
    do_reset();
    slv_mode = 4'd8; trig_sel = 3'b011;
    u0c = n_upd;
    itr_in[3] = 1'b1; wt(10);
    chk("R11 start", cnt_val, 7);
    itr_in[3] = 1'b0; wt(3);
    chk("R11 running", cnt_val, 10);
    itr_in[3] = 1'b1; wt(10);
    chk("R11 reinit", cnt_val, 7);
    chk("R11 upd", n_upd - u0c, 2);
  endtask

  task automatic t_ext();
    do_reset();
    slv_mode = 4'd7; trig_sel = 3'b111; cnt_en = 1'b1;
    for (int i = 0; i < 2; i++) begin
      etr_in = 1'b1; wt(4); etr_in = 1'b0; wt(4);
    end
    chk("R10 ext edges", cnt_val, 2);
    pol_inv = 3'b100; wt(4);
    etr_in = 1'b1; wt(4);
    chk("R12 inverted rise ignored", cnt_val, 2);
    etr_in = 1'b0; wt(4);
    chk("R12 inverted fall counts", cnt_val, 3);
    cnt_en = 1'b0;
    etr_in = 1'b1; wt(4); etr_in = 1'b0; wt(4);
    chk("R10 needs enable", cnt_val, 3);
  endtask

  task automatic t_edsel();
    int t0c;
    do_reset();
    slv_mode = 4'd7; trig_sel = 3'b100; cnt_en = 1'b1;
    t0c = n_trg;
    ti1_in = 1'b1; wt(4); ti1_in = 1'b0; wt(4); ti1_in = 1'b1; wt(4);
    chk("R12 ti1 edge detector", cnt_val, 3);
    chk("R12 edge trg pulses", n_trg - t0c, 3);
  endtask

  task automatic t_err();
    do_reset();
    slv_mode = 4'd5; trig_sel = 3'b100; cnt_en = 1'b1;
    wt(2);
    chk("R13 cfg_err", cfg_err, 1);
    ti1_in = 1'b1; wt(4); ti1_in = 1'b0; wt(6);
    chk("R13 no count", cnt_val, 0);
    trig_sel = 3'b111; wt(1);
    chk("R13 cleared", cfg_err, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_free();
    t_wrap();
    t_enc1();
    t_enc2();
    t_enc3();
    t_rstmode();
    t_gated();
    t_trig();
    t_combo();
    t_ext();
    t_edsel();
    t_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule